// File: doc/BRIEF.md
# Debug Command Memory Access Unit

This unit carries out debug-port commands that have already been decoded. A command names one of eight operations: a system-bus read or write, a continued write or continued read, a read or write of a CPU register, or a read or write of a debug register. Each command ends in one 32-bit response that comes with a status code. Memory operations go out on a simple request/acknowledge system bus. Register operations go out on a separate request/acknowledge register port, which carries a flag that tells CPU registers apart from debug registers.

The unit aligns every memory address to the access size, so an address fault never arises. It zero-extends narrow read data to 32 bits. It remembers the most recent command, so that a continued write or continued read is accepted only when it directly follows the operation it extends. It also refuses CPU register traffic while the core is running, but lets memory and debug-register traffic through at any time. Only one command is in flight at a time, and `cmd_busy` holds off the next command until the response has been issued.

Top module: `dbg_mem_exec`

## Requirements
- R1: For a long access, `cmd_size` 2 or 3, the bus address has its two low bits cleared and `bus_size` reads 2.
- R2: For a word access, `cmd_size` 1, the bus address has bit 0 cleared. For a byte access, `cmd_size` 0, the address goes out unaltered.
- R3: The bus returns read data right-justified. The response carries bits 7:0 for a byte read and bits 15:0 for a word read, with all other bits zero, and the full 32 bits for a long read. Responses to writes carry data 0 and code 0 (OK).
- R4: FILL (op 2) directly after a memory write (op 1) or after a FILL writes `cmd_wdata` with the previous size, at the previous aligned address plus 1, 2 or 4.
- R5: DUMP (op 3) directly after a memory read (op 0) or after a DUMP reads with the previous size, at the previous aligned address plus 1, 2 or 4.
- R6: A FILL or DUMP that does not directly follow its matching command answers with data 32'hFFFF_FFFF and code 1 (illegal). No access is made, and the next FILL or DUMP is also illegal.
- R7: A CPU register command (op 4 read, op 5 write) issued while `core_halted` is 0 answers with data 0 and code 2 (not ready), and makes no access. Memory commands run whatever the value of `core_halted`.
- R8: `bus_req` rises in the cycle after a command is accepted. It stays high, with its address stable, until `bus_ack` is sampled. `rsp_valid` then pulses for exactly one cycle in the following cycle. The bus and register requests are never high together.
- R9: Register commands (ops 4 to 7) drive `reg_req`, with `reg_cpu` set to 1 for ops 4 and 5, `reg_we` set for the writes, and `reg_addr` taken from the low bits of `cmd_addr`. A read returns `reg_rdata` with code 0. Debug register commands (ops 6 and 7) are not gated by the halt state.
- R10: After reset no request or response is active, `cmd_busy` is 0, and no command counts as the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken while cmd_busy is 0 |
| cmd_op | input | 3 | Operation code 0..7 |
| cmd_size | input | 2 | 0 byte, 1 word, 2/3 long |
| cmd_addr | input | AW | Memory address or register number |
| cmd_wdata | input | 32 | Write data |
| core_halted | input | 1 | Core is in the halted state |
| cmd_busy | output | 1 | A command is in flight |
| bus_req | output | 1 | System bus request |
| bus_we | output | 1 | Bus write |
| bus_addr | output | AW | Aligned bus address |
| bus_size | output | 2 | Normalised access size |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | 32 | Right-justified bus read data |
| reg_req | output | 1 | Register port request |
| reg_we | output | 1 | Register write |
| reg_cpu | output | 1 | 1 for a CPU register, 0 for a debug register |
| reg_addr | output | RAW | Register number |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Register access complete |
| reg_rdata | input | 32 | Register read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Response data |
| rsp_code | output | 2 | 0 OK, 1 illegal, 2 not ready |

## Verification
A corrupted record of the previous command shows at the very next FILL or DUMP. Such a command either draws an illegal-code response it should not, or goes out on the bus at the wrong address or size, one cycle after it is accepted. Alignment and formatting faults show in the request cycle or the response cycle of the same command. A fault in the halt gating shows as a not-ready code, or as a register request that should not exist, within a cycle. Because the bench drives acknowledge latencies of zero to three cycles, a request that drops early, or a response strobe that lasts longer than one cycle, is caught within that window.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
   localparam int DW = 32;

   typedef enum logic [2:0] {
      OP_MRD  = 3'd0, OP_MWR  = 3'd1, OP_FILL = 3'd2, OP_DUMP = 3'd3,
      OP_CRD  = 3'd4, OP_CWR  = 3'd5, OP_DRD  = 3'd6, OP_DWR  = 3'd7
   } dbg_op_e;

   typedef enum logic [1:0] {CH_NONE = 2'd0, CH_WR = 2'd1, CH_RD = 2'd2} chain_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUS = 2'd1, ST_REG = 2'd2} xfer_st_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;

   localparam logic [1:0] RC_OK     = 2'd0;
   localparam logic [1:0] RC_ILLEGAL = 2'd1;
   localparam logic [1:0] RC_NOTRDY = 2'd2;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_WORD: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/dbg_addr_align.sv
module dbg_addr_align
   import dbg_mem_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] addr_o
);
   localparam int LOWB = 2;

   generate
      if (AW <= LOWB) begin : g_bad_aw
         $error("dbg_addr_align: AW must exceed %0d", LOWB);
      end
   endgenerate

   always_comb begin
      addr_o = addr_i;
      case (size_i)
         SZ_BYTE: addr_o = addr_i;
         SZ_WORD: addr_o[0] = 1'b0;
         default: addr_o[LOWB-1:0] = '0;
      endcase
   end
endmodule

// File: rtl/dbg_rsp_format.sv
module dbg_rsp_format
   import dbg_mem_pkg::*;
#(
   parameter int W = DW
) (
   input  logic [W-1:0] raw_i,
   input  logic [1:0]   size_i,
   output logic [W-1:0] fmt_o
);
   localparam int NB = W / 8;
   logic [2:0] nbytes;

   generate
      if (W % 8 != 0 || NB > 4) begin : g_bad_w
         $error("dbg_rsp_format: W must be 8, 16, 24 or 32");
      end
   endgenerate

   assign nbytes = size_bytes(size_i);

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign fmt_o[8*i +: 8] = (i < int'(nbytes)) ? raw_i[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/dbg_chain_track.sv
module dbg_chain_track
   import dbg_mem_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_i,
   input  chain_e        kind_i,
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    size_i,
   output logic          fill_ok_o,
   output logic          dump_ok_o,
   output logic [AW-1:0] next_addr_o,
   output logic [1:0]    last_size_o
);
   chain_e        kind_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= CH_NONE;
         addr_q <= '0;
         size_q <= SZ_BYTE;
      end else if (upd_i) begin
         kind_q <= kind_i;
         addr_q <= addr_i;
         size_q <= size_i;
      end
   end

   assign fill_ok_o   = (kind_q == CH_WR);
   assign dump_ok_o   = (kind_q == CH_RD);
   assign last_size_o = size_q;
   assign next_addr_o = addr_q + AW'(size_bytes(size_q));
endmodule

// File: rtl/dbg_mem_exec.sv
module dbg_mem_exec
   import dbg_mem_pkg::*;
#(
   parameter int AW  = 32,
   parameter int RAW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [2:0]     cmd_op,
   input  logic [1:0]     cmd_size,
   input  logic [AW-1:0]  cmd_addr,
   input  logic [31:0]    cmd_wdata,
   input  logic           core_halted,
   output logic           cmd_busy,
   output logic           bus_req,
   output logic           bus_we,
   output logic [AW-1:0]  bus_addr,
   output logic [1:0]     bus_size,
   output logic [31:0]    bus_wdata,
   input  logic           bus_ack,
   input  logic [31:0]    bus_rdata,
   output logic           reg_req,
   output logic           reg_we,
   output logic           reg_cpu,
   output logic [RAW-1:0] reg_addr,
   output logic [31:0]    reg_wdata,
   input  logic           reg_ack,
   input  logic [31:0]    reg_rdata,
   output logic           rsp_valid,
   output logic [31:0]    rsp_data,
   output logic [1:0]     rsp_code
);
   generate
      if (RAW < 1 || RAW > AW) begin : g_bad_raw
         $error("dbg_mem_exec: RAW must be within 1..AW");
      end
   endgenerate

   xfer_st_e      st_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    size_q;
   logic          we_q, cpu_q;
   logic [31:0]   wdata_q;

   dbg_op_e       op;
   logic          accept, is_mem, is_cont, is_wr, illegal, notrdy;
   logic [1:0]    norm_size, eff_size;
   logic [AW-1:0] raw_addr, algn_addr, cont_addr;
   logic          fill_ok, dump_ok;
   logic [1:0]    last_size;
   chain_e        new_kind;
   logic [31:0]   fmt_data;

   assign op        = dbg_op_e'(cmd_op);
   assign accept    = cmd_valid && (st_q == ST_IDLE);
   assign norm_size = cmd_size[1] ? SZ_LONG : cmd_size;
   assign is_cont   = (op == OP_FILL) || (op == OP_DUMP);
   assign is_mem    = (op == OP_MRD) || (op == OP_MWR) || is_cont;
   assign is_wr     = (op == OP_MWR) || (op == OP_FILL) || (op == OP_CWR) || (op == OP_DWR);
   assign illegal   = ((op == OP_FILL) && !fill_ok) || ((op == OP_DUMP) && !dump_ok);
   assign notrdy    = ((op == OP_CRD) || (op == OP_CWR)) && !core_halted;
   assign eff_size  = is_cont ? last_size : norm_size;
   assign raw_addr  = is_cont ? cont_addr : cmd_addr;

   always_comb begin
      if (!is_mem || illegal) new_kind = CH_NONE;
      else if (is_wr)         new_kind = CH_WR;
      else                    new_kind = CH_RD;
   end

   dbg_addr_align #(.AW(AW)) u_align (
      .addr_i(raw_addr), .size_i(eff_size), .addr_o(algn_addr)
   );

   dbg_chain_track #(.AW(AW)) u_chain (
      .clk(clk), .rst_n(rst_n), .upd_i(accept), .kind_i(new_kind),
      .addr_i(algn_addr), .size_i(eff_size), .fill_ok_o(fill_ok),
      .dump_ok_o(dump_ok), .next_addr_o(cont_addr), .last_size_o(last_size)
   );

   dbg_rsp_format #(.W(32)) u_fmt (
      .raw_i(bus_rdata), .size_i(size_q), .fmt_o(fmt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         size_q    <= SZ_BYTE;
         we_q      <= 1'b0;
         cpu_q     <= 1'b0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_code  <= RC_OK;
      end else begin
         rsp_valid <= 1'b0;
         case (st_q)
            ST_IDLE: if (accept) begin
               we_q    <= is_wr;
               cpu_q   <= (op == OP_CRD) || (op == OP_CWR);
               wdata_q <= cmd_wdata;
               if (illegal) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= 32'hFFFF_FFFF;
                  rsp_code  <= RC_ILLEGAL;
               end else if (notrdy) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= '0;
                  rsp_code  <= RC_NOTRDY;
               end else if (is_mem) begin
                  st_q   <= ST_BUS;
                  addr_q <= algn_addr;
                  size_q <= eff_size;
               end else begin
                  st_q   <= ST_REG;
                  addr_q <= cmd_addr;
                  size_q <= SZ_LONG;
               end
            end
            ST_BUS: if (bus_ack) begin
               st_q      <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_data  <= we_q ? 32'h0 : fmt_data;
               rsp_code  <= RC_OK;
            end
            ST_REG: if (reg_ack) begin
               st_q      <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_data  <= we_q ? 32'h0 : reg_rdata;
               rsp_code  <= RC_OK;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_busy  = (st_q != ST_IDLE);
   assign bus_req   = (st_q == ST_BUS);
   assign bus_we    = we_q;
   assign bus_addr  = addr_q;
   assign bus_size  = size_q;
   assign bus_wdata = wdata_q;
   assign reg_req   = (st_q == ST_REG);
   assign reg_we    = we_q;
   assign reg_cpu   = cpu_q;
   assign reg_addr  = addr_q[RAW-1:0];
   assign reg_wdata = wdata_q;
endmodule

// File: rtl/dbg_mem_exec_chk.sv
module dbg_mem_exec_chk #(
   parameter int AW  = 32,
   parameter int RAW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          core_halted,
   input logic          cmd_busy,
   input logic          bus_req,
   input logic [AW-1:0] bus_addr,
   input logic [1:0]    bus_size,
   input logic          bus_ack,
   input logic          reg_req,
   input logic          reg_cpu,
   input logic          rsp_valid,
   input logic [31:0]   rsp_data,
   input logic [1:0]    rsp_code
);
   a_r1_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == 2'd2 |-> bus_addr[1:0] == 2'b00);

   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == 2'd1 |-> bus_addr[0] == 1'b0);

   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size));

   a_r8_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> rsp_valid && !bus_req);

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && reg_req));

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid || !cmd_busy);

   a_r6_illegal_word: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == 2'd1 |-> rsp_data == 32'hFFFF_FFFF);

   a_r7_cpu_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_req) && reg_cpu |-> $past(core_halted));
endmodule

bind dbg_mem_exec dbg_mem_exec_chk #(.AW(AW), .RAW(RAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .cmd_busy(cmd_busy),
   .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size), .bus_ack(bus_ack),
   .reg_req(reg_req), .reg_cpu(reg_cpu), .rsp_valid(rsp_valid),
   .rsp_data(rsp_data), .rsp_code(rsp_code)
);

// File: tb/tb_dbg_mem_exec.sv
module tb_dbg_mem_exec;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int RAW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [1:0] cmd_size = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [31:0] cmd_wdata = '0;
   logic core_halted = 1'b0;
   logic cmd_busy, bus_req, bus_we, reg_req, reg_we, reg_cpu, rsp_valid;
   logic [AW-1:0] bus_addr;
   logic [1:0] bus_size, rsp_code;
   logic [31:0] bus_wdata, reg_wdata, rsp_data;
   logic [RAW-1:0] reg_addr;
   logic bus_ack = 1'b0, reg_ack = 1'b0;
   logic [31:0] bus_rdata = '0, reg_rdata = '0;

   int total = 0, bad = 0;
   bit done = 0;

   // behavioural model of the previous-command record: 0 none, 1 write, 2 read
   int m_kind = 0;
   logic [AW-1:0] m_addr = '0;
   int m_size = 0;

   dbg_mem_exec #(.AW(AW), .RAW(RAW)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_val(input logic [AW-1:0] a);
      return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11, a[7:0] ^ 8'hC3, a[7:0] | 8'h80};
   endfunction

   function automatic int nb(input int s);
      return (s == 0) ? 1 : (s == 1) ? 2 : 4;
   endfunction

   // every clock: bus and register requests never overlap (R8)
   always @(negedge clk) if (rst_n && !done)
      chk(!(bus_req && reg_req), "R8 exclusive requests", {bus_req, reg_req}, 0);

   task automatic run(input int op, input int size, input logic [AW-1:0] addr,
                      input logic [31:0] wd, input int lat, input string tag);
      int kind_exp;           // 0 illegal, 1 notready, 2 bus, 3 reg
      int sz;
      logic [AW-1:0] a;
      logic [31:0] exp_data, rd;
      bit wr;
      sz = (size >= 2) ? 2 : size;
      wr = (op == 1 || op == 2 || op == 5 || op == 7);
      if ((op == 2 && m_kind != 1) || (op == 3 && m_kind != 2)) kind_exp = 0;
      else if ((op == 4 || op == 5) && !core_halted) kind_exp = 1;
      else if (op <= 3) kind_exp = 2;
      else kind_exp = 3;
      if (op == 2 || op == 3) begin
         sz = m_size;
         a = m_addr + AW'(nb(m_size));
      end else a = addr;
      if (sz == 2) a[1:0] = 2'b00;
      else if (sz == 1) a[0] = 1'b0;

      cmd_op = 3'(op); cmd_size = 2'(size); cmd_addr = addr; cmd_wdata = wd; cmd_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_valid = 1'b0;
      if (kind_exp <= 1) begin
         chk(rsp_valid === 1'b1, {tag, " rsp strobe"}, rsp_valid, 1);
         chk(rsp_code === ((kind_exp == 0) ? 2'd1 : 2'd2), {tag, " code"}, rsp_code, (kind_exp == 0) ? 1 : 2);
         chk(rsp_data === ((kind_exp == 0) ? 32'hFFFF_FFFF : 32'h0), {tag, " data"}, rsp_data,
             (kind_exp == 0) ? 32'hFFFF_FFFF : 0);
         chk(!bus_req && !reg_req && !cmd_busy, {tag, " no access"}, {bus_req, reg_req}, 0);
         m_kind = 0;
      end else if (kind_exp == 2) begin
         chk(bus_req === 1'b1 && bus_addr === a && bus_size === 2'(sz) && bus_we === wr,
             {tag, " bus request"}, {bus_req, bus_we, bus_size, bus_addr}, {1'b1, wr, 2'(sz), a});
         if (wr) chk(bus_wdata === wd, {tag, " bus wdata"}, bus_wdata, wd);
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(bus_req && cmd_busy && bus_addr === a && !rsp_valid, {tag, " R8 req held"}, bus_addr, a);
         end
         rd = mem_val(a);
         bus_rdata = rd; bus_ack = 1'b1;
         @(negedge clk);
         bus_ack = 1'b0; bus_rdata = 32'hDEAD_BEEF;
         exp_data = wr ? 32'h0 : (sz == 0) ? {24'h0, rd[7:0]} : (sz == 1) ? {16'h0, rd[15:0]} : rd;
         chk(rsp_valid && !bus_req && rsp_code === 2'd0, {tag, " R8 rsp after ack"}, {rsp_valid, rsp_code}, 3'b100);
         chk(rsp_data === exp_data, {tag, " R3 rsp data"}, rsp_data, exp_data);
         m_kind = wr ? 1 : 2; m_addr = a; m_size = sz;
      end else begin
         chk(reg_req === 1'b1 && reg_cpu === (op <= 5) && reg_we === wr && reg_addr === addr[RAW-1:0],
             {tag, " R9 reg request"}, {reg_req, reg_cpu, reg_we, reg_addr}, {1'b1, op <= 5, wr, addr[RAW-1:0]});
         if (wr) chk(reg_wdata === wd, {tag, " R9 reg wdata"}, reg_wdata, wd);
         for (int i = 0; i < lat; i++) @(negedge clk);
         rd = 32'h1234_0000 | {24'h0, addr[7:0]};
         reg_rdata = rd; reg_ack = 1'b1;
         @(negedge clk);
         reg_ack = 1'b0;
         exp_data = wr ? 32'h0 : rd;
         chk(rsp_valid && rsp_code === 2'd0 && rsp_data === exp_data, {tag, " R9 reg rsp"}, rsp_data, exp_data);
         m_kind = 0;
      end
      @(negedge clk);
      chk(!rsp_valid && !cmd_busy, {tag, " R8 single pulse"}, {rsp_valid, cmd_busy}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !reg_req && !rsp_valid && !cmd_busy, "R10 reset state",
          {bus_req, reg_req, rsp_valid, cmd_busy}, 0);
      run(2, 0, 0, 32'h1, 0, "R10 R6 fill after reset");
      run(1, 3, 32'h0000_1003, 32'hA1B2_C3D4, 1, "R1 long write");
      run(2, 0, 32'hFFFF_FFFF, 32'h0000_0011, 0, "R4 fill 1");
      run(2, 1, 32'h0, 32'h0000_0022, 3, "R4 fill 2");
      run(0, 0, 32'h0000_2001, 0, 2, "R2 R3 byte read");
      run(3, 0, 0, 0, 0, "R5 dump byte");
      run(0, 1, 32'h0000_3003, 0, 1, "R2 R3 word read");
      run(3, 2, 0, 0, 3, "R5 dump word");
      run(0, 2, 32'h0000_4006, 0, 0, "R1 R3 long read");
      run(2, 0, 0, 32'h5, 0, "R6 fill after read");
      run(3, 0, 0, 0, 0, "R6 dump after illegal");
      run(1, 1, 32'h0000_5005, 32'h0000_BEEF, 0, "R2 word write");
      run(3, 0, 0, 0, 0, "R6 dump after write");
      run(4, 2, 32'h0000_000F, 0, 0, "R7 cpu read running");
      run(0, 2, 32'h0000_6000, 0, 1, "R7 memory while running");
      run(5, 2, 32'h0000_0003, 32'h9, 0, "R7 cpu write running");
      run(3, 0, 0, 0, 0, "R6 dump after cpu cmd");
      run(6, 2, 32'h0000_0021, 0, 2, "R9 debug read running");
      run(7, 2, 32'h0000_0022, 32'h0000_7777, 0, "R9 debug write");
      core_halted = 1'b1;
      run(4, 2, 32'h0000_0031, 0, 1, "R9 cpu read halted");
      run(5, 2, 32'h0000_0032, 32'hCAFE_F00D, 0, "R9 cpu write halted");
      run(0, 1, 32'h0000_7001, 0, 0, "R7 memory while halted");
      run(3, 0, 0, 0, 2, "R5 dump while halted");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule